// File: doc/BRIEF.md
# Two-Dimensional Parity Error Locator

This block checks a fixed-length frame of bytes as it streams in and, at the end of the frame, says whether exactly one bit was flipped. If one was, it gives the position of that bit and the repaired byte. Each byte is one row. It carries a 7-bit character in its low bits and a parity bit in bit 7, and every row uses odd parity. The last byte of the frame is a check byte. It makes each of the 8 bit columns odd across the whole frame, and this includes the check byte's own bits.

Bytes enter through a valid/ready port. A byte is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while reset is asserted, so the block never holds back a sender that is out of reset. A byte accepted with `in_sof` high opens a new frame as byte 0. A frame ends with its twelfth accepted byte. The block keeps every row in a small register file so that it can repair the bad byte after the frame ends. It reports through a one-cycle `done` strobe and plain status pins.

Top module: `parity2d_locator`

## Requirements
- R1: While `rst` is high, `in_ready`, `done`, `single_error` and `multi_error` are all low, and no frame is open. From the first edge after `rst` falls, `in_ready` stays high.
- R2: An accepted byte with `in_sof`=1 starts a frame as byte 0. This clears all column sums and row flags, and it also applies when a frame is already open, which is then dropped.
- R3: `done` is high for exactly one cycle. That is the cycle right after the edge that accepts the twelfth byte of a frame (index 11). The result pins are only nonzero while `done` is high.
- R4: A row passes when its 8 bits hold an odd number of ones. A column passes when bit j summed over all 12 bytes is odd. A frame in which every row and column passes gives `done` with `single_error`=0 and `multi_error`=0.
- R5: When exactly one row and exactly one column fail, `single_error`=1. `err_row` gives the failing byte index (0 = first byte, 11 = check byte) and `err_col` gives the failing bit number (0 = LSB, 7 = parity bit).
- R6: With `single_error`=1, `fixed_byte` is the stored byte at `err_row` with bit `err_col` inverted.
- R7: Any other nonzero pattern of failures gives `multi_error`=1 and `single_error`=0, with `err_row`, `err_col` and `fixed_byte` all 0. This covers failing columns with no failing row and failing rows with no failing column.
- R8: A cycle with `in_valid`=0 has no effect. A byte with `in_sof`=0 while no frame is open is dropped and does not start a frame.
- R9: The block applies no back-pressure, so frames with idle gaps between bytes give the same result as frames sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Block accepts a byte; low only during reset |
| in_sof | input | 1 | Offered byte is byte 0 of a frame |
| in_data | input | 8 | Offered byte; bit 7 is the row parity bit |
| done | output | 1 | One-cycle strobe: frame results valid |
| single_error | output | 1 | Exactly one bit found flipped |
| multi_error | output | 1 | Uncorrectable failure pattern |
| err_row | output | 4 | Byte index of the flipped bit |
| err_col | output | 3 | Bit number of the flipped bit |
| fixed_byte | output | 8 | Repaired byte |

## Verification
All results come from registers that the final byte's accepting edge updates. So `done` and its result pins are due one cycle after the twelfth byte is accepted and are gone one cycle later. The bench drives and samples on the falling edge. It reads the results at the first falling edge after the last byte is driven, and it checks that `done` is low again at the next falling edge. During every byte of every frame it also counts any `done` it sees, which catches a frame that closes early. Expected indices and repaired bytes are computed from which bit the bench flipped.

// File: rtl/p2d_pkg.sv
package p2d_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_SINGLE = 2'd1,
    CLS_MULTI  = 2'd2
  } p2d_class_e;
endpackage

// File: rtl/p2d_frame_ctrl.sv
module p2d_frame_ctrl #(
  parameter int NUM_ROWS = 12,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             sof,
  output logic             take,
  output logic             start,
  output logic [ROW_W-1:0] row_idx,
  output logic             done
);
  logic             busy;
  logic [ROW_W-1:0] count;
  logic             last;

  always_comb begin
    start   = accept && sof;
    take    = accept && (sof || busy);
    row_idx = sof ? '0 : count;
    last    = take && (row_idx == ROW_W'(NUM_ROWS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (last) begin
        busy  <= 1'b0;
        count <= '0;
      end else if (take) begin
        busy  <= 1'b1;
        count <= row_idx + 1'b1;
      end
    end
  end

  assert_done_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    count < ROW_W'(NUM_ROWS));
  assert_idle_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && accept && !sof) |=> (count == '0));
endmodule

// File: rtl/p2d_col_accum.sv
module p2d_col_accum #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] col_fail
);
  logic [DATA_W-1:0] col_sum;

  always_ff @(posedge clk) begin
    if (rst)        col_sum <= '0;
    else if (start) col_sum <= data;
    else if (take)  col_sum <= col_sum ^ data;
  end

  // odd parity per column: a sum of 0 means the column failed
  assign col_fail = ~col_sum;

  assert_sof_restarts_sum_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (col_sum == $past(data)));
endmodule

// File: rtl/p2d_row_store.sv
module p2d_row_store #(
  parameter int NUM_ROWS = 12,
  parameter int DATA_W   = 8,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       take,
  input  logic                       start,
  input  logic [ROW_W-1:0]           row_idx,
  input  logic [DATA_W-1:0]          data,
  output logic [NUM_ROWS-1:0]        row_fail,
  output logic [NUM_ROWS*DATA_W-1:0] rows_flat
);
  logic [DATA_W-1:0] rows [NUM_ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      row_fail <= '0;
    end else if (take) begin
      if (start) row_fail <= '0;
      row_fail[row_idx] <= ~(^data);
    end
  end

  always_ff @(posedge clk) begin
    if (take) rows[row_idx] <= data;
  end

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_flat
    assign rows_flat[g*DATA_W +: DATA_W] = rows[g];
  end

  assert_row_flag_tracks_parity_R4: assert property (@(posedge clk) disable iff (rst)
    take |=> (row_fail[$past(row_idx)] == ~(^$past(data))));
endmodule

// File: rtl/p2d_locator.sv
module p2d_locator
  import p2d_pkg::*;
#(
  parameter int NUM_ROWS = 12,
  parameter int DATA_W   = 8,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int COL_W = $clog2(DATA_W)
) (
  input  logic [NUM_ROWS-1:0]        row_fail,
  input  logic [DATA_W-1:0]          col_fail,
  input  logic [NUM_ROWS*DATA_W-1:0] rows_flat,
  output p2d_class_e                 cls,
  output logic [ROW_W-1:0]           row_pos,
  output logic [COL_W-1:0]           col_pos,
  output logic [DATA_W-1:0]          repaired
);
  logic row_one, col_one, any_fail;
  logic [ROW_W-1:0]  r_idx;
  logic [COL_W-1:0]  c_idx;
  logic [DATA_W-1:0] picked;

  always_comb begin
    row_one  = (row_fail != '0) && ((row_fail & (row_fail - 1'b1)) == '0);
    col_one  = (col_fail != '0) && ((col_fail & (col_fail - 1'b1)) == '0);
    any_fail = (row_fail != '0) || (col_fail != '0);

    r_idx  = '0;
    picked = '0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      if (row_fail[i]) begin
        r_idx  = ROW_W'(i);
        picked = rows_flat[i*DATA_W +: DATA_W];
      end
    end
    c_idx = '0;
    for (int j = 0; j < DATA_W; j++) begin
      if (col_fail[j]) c_idx = COL_W'(j);
    end

    if (row_one && col_one) begin
      cls      = CLS_SINGLE;
      row_pos  = r_idx;
      col_pos  = c_idx;
      repaired = picked ^ col_fail;
    end else begin
      cls      = any_fail ? CLS_MULTI : CLS_CLEAN;
      row_pos  = '0;
      col_pos  = '0;
      repaired = '0;
    end
  end
endmodule

// File: rtl/parity2d_locator.sv
module parity2d_locator
  import p2d_pkg::*;
#(
  parameter int NUM_ROWS = 12,
  parameter int DATA_W   = 8,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int COL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_data,
  output logic              done,
  output logic              single_error,
  output logic              multi_error,
  output logic [ROW_W-1:0]  err_row,
  output logic [COL_W-1:0]  err_col,
  output logic [DATA_W-1:0] fixed_byte
);
  logic                       accept, take, start, frame_done;
  logic [ROW_W-1:0]           row_idx;
  logic [NUM_ROWS-1:0]        row_fail;
  logic [DATA_W-1:0]          col_fail;
  logic [NUM_ROWS*DATA_W-1:0] rows_flat;
  p2d_class_e                 cls;
  logic [ROW_W-1:0]           row_pos;
  logic [COL_W-1:0]           col_pos;
  logic [DATA_W-1:0]          repaired;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  assign accept = in_valid && in_ready;

  p2d_frame_ctrl #(.NUM_ROWS(NUM_ROWS)) u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .sof(in_sof),
    .take(take), .start(start), .row_idx(row_idx), .done(frame_done)
  );

  p2d_col_accum #(.DATA_W(DATA_W)) u_cols (
    .clk(clk), .rst(rst), .take(take), .start(start),
    .data(in_data), .col_fail(col_fail)
  );

  p2d_row_store #(.NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W)) u_rows (
    .clk(clk), .rst(rst), .take(take), .start(start), .row_idx(row_idx),
    .data(in_data), .row_fail(row_fail), .rows_flat(rows_flat)
  );

  p2d_locator #(.NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W)) u_loc (
    .row_fail(row_fail), .col_fail(col_fail), .rows_flat(rows_flat),
    .cls(cls), .row_pos(row_pos), .col_pos(col_pos), .repaired(repaired)
  );

  always_comb begin
    done         = frame_done;
    single_error = frame_done && (cls == CLS_SINGLE);
    multi_error  = frame_done && (cls == CLS_MULTI);
    err_row      = single_error ? row_pos  : '0;
    err_col      = single_error ? col_pos  : '0;
    fixed_byte   = single_error ? repaired : '0;
  end

  assert_flags_need_done_R3: assert property (@(posedge clk) disable iff (rst)
    (single_error || multi_error || fixed_byte != '0) |-> done);
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(single_error && multi_error));
  assert_repair_is_odd_R6: assert property (@(posedge clk) disable iff (rst)
    single_error |-> (^fixed_byte));
  assert_row_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    single_error |-> (err_row < ROW_W'(NUM_ROWS)));
  assert_ready_in_reset_R1: assert property (@(posedge clk)
    rst |=> !in_ready);
endmodule

// File: tb/tb_parity2d_locator.sv
module tb_parity2d_locator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, done, single_error, multi_error;
  logic [3:0] err_row;
  logic [2:0] err_col;
  logic [7:0] fixed_byte;

  always #2 clk = ~clk;

  parity2d_locator dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .done(done),
    .single_error(single_error), .multi_error(multi_error),
    .err_row(err_row), .err_col(err_col), .fixed_byte(fixed_byte)
  );

  int tests = 0, fails = 0;
  logic [7:0] frm [12];
  logic [7:0] good [12];
  logic r_done, r_single, r_multi;
  logic [3:0] r_row;
  logic [2:0] r_col;
  logic [7:0] r_fixed;
  int early_done;

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build(input int seed);
    logic [7:0] colx;
    logic [6:0] c;
    colx = '0;
    for (int i = 0; i < 11; i++) begin
      c = 7'((32 + i * 7 + seed * 13) % 95 + 32);
      good[i] = {~(^c), c};
      colx = colx ^ good[i];
    end
    good[11] = ~colx;
    for (int i = 0; i < 12; i++) frm[i] = good[i];
  endtask

  task automatic send(input int gap);
    early_done = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) early_done++;
      in_valid = 1'b1; in_sof = (i == 0); in_data = frm[i];
      if (gap > 0 && i < 11) begin
        repeat (gap) begin
          @(negedge clk);
          if (done) early_done++;
          in_valid = 1'b0; in_sof = 1'b0; in_data = 8'hA5;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    r_done = done; r_single = single_error; r_multi = multi_error;
    r_row = err_row; r_col = err_col; r_fixed = fixed_byte;
    @(negedge clk);
    chk("R3", "done clears after one cycle", int'(done), 0);
    chk("R3", "no early done", early_done, 0);
  endtask

  task automatic expect_clean(input string req);
    chk(req, "done", int'(r_done), 1);
    chk(req, "single", int'(r_single), 0);
    chk(req, "multi", int'(r_multi), 0);
  endtask

  task automatic expect_multi(input string req);
    chk(req, "done", int'(r_done), 1);
    chk(req, "multi", int'(r_multi), 1);
    chk("R7", "single", int'(r_single), 0);
    chk("R7", "zeroed outputs", int'({r_row, r_col, r_fixed}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(in_ready), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "flags in reset", int'(single_error | multi_error), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", int'(in_ready), 1);
    chk("R1", "done after reset", int'(done), 0);

    // R4: clean frames
    for (int s = 0; s < 3; s++) begin
      build(s); send(0); expect_clean("R4");
    end

    // R5 R6: every single-bit position
    for (int r = 0; r < 12; r++) begin
      for (int c = 0; c < 8; c++) begin
        build(r + c);
        frm[r][c] = ~frm[r][c];
        send(0);
        chk("R5", "single", int'(r_single), 1);
        chk("R5", "multi", int'(r_multi), 0);
        chk("R5", "row", int'(r_row), r);
        chk("R5", "col", int'(r_col), c);
        chk("R6", "fixed", int'(r_fixed), int'(good[r]));
      end
    end

    // R7: two flips in one row, columns fail without a row
    build(4); frm[3][1] = ~frm[3][1]; frm[3][5] = ~frm[3][5]; send(0); expect_multi("R7");
    // R7: same column in two rows, rows fail without a column
    build(5); frm[2][6] = ~frm[2][6]; frm[9][6] = ~frm[9][6]; send(0); expect_multi("R7");
    // R7: diagonal pair
    build(6); frm[0][0] = ~frm[0][0]; frm[7][4] = ~frm[7][4]; send(0); expect_multi("R7");
    // R7: three flips
    build(7); frm[1][2] = ~frm[1][2]; frm[1][3] = ~frm[1][3]; frm[10][7] = ~frm[10][7];
    send(0); expect_multi("R7");

    // R9: idle gaps between bytes
    build(8); frm[6][3] = ~frm[6][3]; send(2);
    chk("R9", "single with gaps", int'(r_single), 1);
    chk("R9", "row with gaps", int'(r_row), 6);
    chk("R9", "col with gaps", int'(r_col), 3);
    chk("R9", "ready held", int'(in_ready), 1);

    // R8: bytes without sof while idle are dropped
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_data = 8'h00;
    end
    @(negedge clk); in_valid = 1'b0;
    chk("R8", "no done from stray bytes", int'(done), 0);
    build(9); send(0); expect_clean("R8");

    // R2: sof mid-frame restarts
    build(10);
    frm[0] = 8'h00;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (k == 0); in_data = frm[k];
    end
    build(11); send(0); expect_clean("R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule